// File: doc/BRIEF.md
# Fifth-order single-bit noise shaper

This block turns a stream of signed fixed-point audio samples into a one-bit stream whose running average follows the input. The block is meant to feed a one-bit DAC running at the oversampled rate. The nominal rate is 64 times a 44.1 kHz Nyquist rate, so about 2.822 MHz per output bit. A chain of five delaying integrators with power-of-two gains forms the loop filter. Their states are scaled by shifts, summed, and passed to a sign decision. The decision drives a feedback of plus or minus full scale into the first integrator. Two small negative feedback paths act as resonators. One returns the third state to the second integrator's input and the other returns the fifth state to the fourth integrator's input. Together they put two notches into the noise spectrum inside the audio band.

A 23-bit maximal-length shift register supplies a small signed dither word to the first integrator when dithering is enabled. This breaks up the idle tones that a constant input would otherwise produce. A run-length watchdog counts identical consecutive output bits. When the run reaches a programmable limit, the watchdog treats the loop as overloaded. It then zeroes every integrator in that same sample and raises a sticky flag.

Samples arrive on a valid/ready input. The block never applies back-pressure: ready is high whenever reset is low. Every accepted sample advances the loop by exactly one step. A cycle without a sample freezes the loop and the output bit. The output is a plain bit with a one-cycle valid strobe and cannot be stalled.

Top module: `sd5_modulator`

## Requirements
- R1: `s_ready` is low during reset and high otherwise. Each cycle with `s_valid && s_ready` performs one loop step, and in the next cycle `bit_valid` is 1 and `bit_out` holds that step's decision. A cycle without a sample leaves `bit_valid` at 0 next cycle and keeps `bit_out`, `ovl_flag` and all loop state unchanged.
- R2: Reset (synchronous, active-high `rst`) drives `bit_out`, `bit_valid` and `ovl_flag` to 0 and zeroes all five integrator states.
- R3: The decision is 1 (meaning +1) when the weighted state sum is zero or positive, and 0 (meaning -1) otherwise. The feedback applied to the first integrator is +2^(DW-1) for 1 and -2^(DW-1) for 0. With cleared states, zero input and dither off, the first two bits are therefore 1, then 0.
- R4: The integrator gains are 1, 1, 1/2, 1/4, 1/8 and the sum weights are 1, 1/2, 1/4, 1/8, 1/8. The resonator gains are 1/1024 and 1/16-1/64. For a constant input c well inside full scale, the fraction of ones over 4096 bits is within 48/4096 of (1 + c/2^(DW-1))/2.
- R5: A zero input with `ovl_limit` = 64 never triggers the watchdog over 4096 samples.
- R6: The watchdog trips in a step whose identical-bit run, including the new bit, reaches a nonzero `ovl_limit`. In that step all integrators are written to zero instead of updated. With a full-scale input and limit 64, the watchdog trips. After a trip, a zero input yields the bits 1, 0. An `ovl_limit` of 0 disables the watchdog.
- R7: `ovl_flag` is set by any trip and stays set until `ovl_clr` is high in a cycle without a trip. A trip wins over a simultaneous clear.
- R8: When `dither_en` is high, the low DITH_W bits of a 23-bit LFSR (taps 23 and 18) are added as a signed value at the first integrator input, stepping once per sample. The R4 average bound still holds with dither on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_valid | input | 1 | Input sample valid |
| s_ready | output | 1 | Ready; high whenever not in reset |
| s_data | input | DW | Signed input sample, full scale ±2^(DW-1) |
| dither_en | input | 1 | Adds LFSR dither at the first integrator |
| ovl_limit | input | RUN_W | Run length that trips the watchdog; 0 disables it |
| ovl_clr | input | 1 | Clears the sticky overload flag |
| bit_valid | output | 1 | One-cycle strobe after each accepted sample |
| bit_out | output | 1 | Output bit, 1 = +1, 0 = -1 |
| ovl_flag | output | 1 | Sticky overload indication |

## Verification
Each output bit is due in the cycle after the edge that accepts its sample. A trip is visible on `ovl_flag` in that same cycle, and the cleared states appear in the two bits that follow. The bench drives inputs on the falling edge and reads results on the next falling edge, one rising edge later, so every bit is compared against the step that produced it. The average checks first discard 512 settling samples. They then count ones over exactly 4096 consecutive strobes, so the loop's bounded first-integrator state limits the deviation to a few bits.

// File: rtl/sd5_pkg.sv
package sd5_pkg;
  localparam int NSTAGE = 5;
  // integrator gains as right shifts: 1, 1, 1/2, 1/4, 1/8
  localparam int INT_SH [NSTAGE] = '{0, 0, 1, 2, 3};
  // feed-forward weights into the comparator: 1, 1/2, 1/4, 1/8, 1/8
  localparam int FF_SH  [NSTAGE] = '{0, 1, 2, 3, 3};
  // resonator A: state 3 -> integrator 2 input, gain 1/1024
  localparam int RES_A_SH  = 10;
  // resonator B: state 5 -> integrator 4 input, gain 1/16 - 1/64
  localparam int RES_B_SH1 = 4;
  localparam int RES_B_SH2 = 6;
  localparam int LFSR_W = 23;
  localparam int LFSR_TAP = 18;
endpackage

// File: rtl/sd5_integrator.sv
module sd5_integrator #(
  parameter int SW = 24,
  parameter int PW = 26
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic                 clr,
  input  logic signed [PW-1:0] inc,
  output logic signed [SW-1:0] st
);
  localparam logic signed [PW:0] HI = $signed({{(PW+2-SW){1'b0}}, {(SW-1){1'b1}}});
  localparam logic signed [PW:0] LO = $signed({{(PW+2-SW){1'b1}}, {(SW-1){1'b0}}});

  logic signed [PW:0] sum;
  assign sum = $signed({{(PW+1-SW){st[SW-1]}}, st}) + $signed({inc[PW-1], inc});

  always_ff @(posedge clk) begin
    if (rst)
      st <= '0;
    else if (en) begin
      if (clr)           st <= '0;
      else if (sum > HI) st <= HI[SW-1:0];
      else if (sum < LO) st <= LO[SW-1:0];
      else               st <= sum[SW-1:0];
    end
  end
endmodule

// File: rtl/sd5_loop_filter.sv
module sd5_loop_filter
  import sd5_pkg::*;
#(
  parameter int DW    = 16,
  parameter int GUARD = 8,
  parameter int FB_SH = 0
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      en,
  input  logic                      clr,
  input  logic signed [DW+GUARD-1:0] drive,
  output logic                      y
);
  localparam int SW = DW + GUARD;
  localparam int PW = SW + 2;
  localparam int QW = SW + 3;
  localparam logic signed [PW-1:0] FBP = $signed(PW'(1) << (DW - 1 + FB_SH));

  function automatic logic signed [PW-1:0] ext(input logic signed [SW-1:0] v);
    return $signed({{(PW-SW){v[SW-1]}}, v});
  endfunction

  logic signed [SW-1:0] st  [NSTAGE];
  logic signed [PW-1:0] pre [NSTAGE];
  logic signed [PW-1:0] fbv;
  logic signed [QW-1:0] qsum;

  always_comb begin
    fbv    = y ? FBP : -FBP;
    pre[0] = ext(drive) - fbv;
    pre[1] = ext(st[0]) - (ext(st[2]) >>> RES_A_SH);
    pre[2] = ext(st[1]);
    pre[3] = ext(st[2]) - (ext(st[4]) >>> RES_B_SH1) + (ext(st[4]) >>> RES_B_SH2);
    pre[4] = ext(st[3]);
  end

  for (genvar g = 0; g < NSTAGE; g++) begin : g_int
    logic signed [PW-1:0] inc;
    assign inc = pre[g] >>> INT_SH[g];
    sd5_integrator #(.SW(SW), .PW(PW)) u_int (
      .clk(clk), .rst(rst), .en(en), .clr(clr), .inc(inc), .st(st[g])
    );
  end

  always_comb begin
    qsum = '0;
    for (int i = 0; i < NSTAGE; i++)
      qsum = qsum + ($signed({{(QW-SW){st[i][SW-1]}}, st[i]}) >>> FF_SH[i]);
    y = ~qsum[QW-1];
  end
endmodule

// File: rtl/sd5_dither.sv
module sd5_dither
  import sd5_pkg::*;
#(
  parameter int DITH_W = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     en,
  output logic signed [DITH_W-1:0] dith
);
  logic [LFSR_W-1:0] r;

  always_ff @(posedge clk) begin
    if (rst)     r <= LFSR_W'(1);
    else if (en) r <= {r[LFSR_W-2:0], r[LFSR_W-1] ^ r[LFSR_TAP-1]};
  end

  assign dith = $signed(r[DITH_W-1:0]);
endmodule

// File: rtl/sd5_overload.sv
module sd5_overload #(
  parameter int RUN_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic             y,
  input  logic             prev,
  input  logic [RUN_W-1:0] limit,
  input  logic             clr,
  output logic             trip,
  output logic             flag
);
  localparam logic [RUN_W-1:0] RMAX = '1;

  logic [RUN_W-1:0] run_len;
  logic [RUN_W-1:0] nxt_len;

  always_comb begin
    if (y != prev)           nxt_len = RUN_W'(1);
    else if (run_len == RMAX) nxt_len = RMAX;
    else                     nxt_len = run_len + RUN_W'(1);
    trip = step && (limit != '0) && (nxt_len >= limit);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_len <= '0;
      flag    <= 1'b0;
    end else begin
      if (step) run_len <= trip ? '0 : nxt_len;
      if (trip)     flag <= 1'b1;
      else if (clr) flag <= 1'b0;
    end
  end
endmodule

// File: rtl/sd5_modulator.sv
module sd5_modulator #(
  parameter int DW     = 16,
  parameter int GUARD  = 8,
  parameter int FB_SH  = 0,
  parameter int DITH_W = 4,
  parameter int RUN_W  = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             s_valid,
  output logic             s_ready,
  input  logic [DW-1:0]    s_data,
  input  logic             dither_en,
  input  logic [RUN_W-1:0] ovl_limit,
  input  logic             ovl_clr,
  output logic             bit_valid,
  output logic             bit_out,
  output logic             ovl_flag
);
  localparam int SW = DW + GUARD;

  logic                     step;
  logic                     y;
  logic                     trip;
  logic signed [DITH_W-1:0] dith;
  logic signed [SW-1:0]     drive;

  assign s_ready = ~rst;
  assign step    = s_valid & s_ready;

  always_comb begin
    drive = $signed({{(SW-DW){s_data[DW-1]}}, s_data});
    if (dither_en)
      drive = drive + $signed({{(SW-DITH_W){dith[DITH_W-1]}}, dith});
  end

  sd5_dither #(.DITH_W(DITH_W)) u_dither (
    .clk(clk), .rst(rst), .en(step), .dith(dith)
  );

  sd5_loop_filter #(.DW(DW), .GUARD(GUARD), .FB_SH(FB_SH)) u_loop (
    .clk(clk), .rst(rst), .en(step), .clr(trip), .drive(drive), .y(y)
  );

  sd5_overload #(.RUN_W(RUN_W)) u_ovl (
    .clk(clk), .rst(rst), .step(step), .y(y), .prev(bit_out),
    .limit(ovl_limit), .clr(ovl_clr), .trip(trip), .flag(ovl_flag)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_valid <= 1'b0;
      bit_out   <= 1'b0;
    end else begin
      bit_valid <= step;
      if (step) bit_out <= y;
    end
  end
endmodule

// File: rtl/sd5_modulator_chk.sv
module sd5_modulator_chk #(
  parameter int RUN_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             s_valid,
  input logic             s_ready,
  input logic [RUN_W-1:0] ovl_limit,
  input logic             ovl_clr,
  input logic             bit_valid,
  input logic             bit_out,
  input logic             ovl_flag
);
  assert_strobe_R1: assert property (@(posedge clk) disable iff (rst)
    (s_valid && s_ready) |=> bit_valid);

  assert_no_strobe_R1: assert property (@(posedge clk) disable iff (rst)
    !(s_valid && s_ready) |=> !bit_valid);

  assert_hold_bit_R1: assert property (@(posedge clk) disable iff (rst)
    !(s_valid && s_ready) |=> $stable(bit_out));

  assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    (ovl_flag && !ovl_clr) |=> ovl_flag);

  assert_flag_set_on_step_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(ovl_flag) |-> bit_valid);

  assert_clear_wins_idle_R7: assert property (@(posedge clk) disable iff (rst)
    (ovl_clr && !(s_valid && s_ready)) |=> !ovl_flag);

  assert_disabled_no_trip_R6: assert property (@(posedge clk) disable iff (rst)
    (ovl_limit == '0 && !ovl_flag) |=> !ovl_flag);
endmodule

bind sd5_modulator sd5_modulator_chk #(.RUN_W(RUN_W)) u_chk (
  .clk(clk), .rst(rst), .s_valid(s_valid), .s_ready(s_ready),
  .ovl_limit(ovl_limit), .ovl_clr(ovl_clr), .bit_valid(bit_valid),
  .bit_out(bit_out), .ovl_flag(ovl_flag)
);

// File: tb/sd5_modulator_tb.sv
module sd5_modulator_tb;
  localparam int DW = 16;
  localparam int RUN_W = 8;
  localparam int FS = 32768;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             s_valid = 1'b0;
  logic             s_ready;
  logic [DW-1:0]    s_data = '0;
  logic             dither_en = 1'b0;
  logic [RUN_W-1:0] ovl_limit = 8'd64;
  logic             ovl_clr = 1'b0;
  logic             bit_valid;
  logic             bit_out;
  logic             ovl_flag;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  sd5_modulator u_dut (
    .clk(clk), .rst(rst), .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .dither_en(dither_en), .ovl_limit(ovl_limit), .ovl_clr(ovl_clr),
    .bit_valid(bit_valid), .bit_out(bit_out), .ovl_flag(ovl_flag)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; s_valid = 1'b0; s_data = '0; dither_en = 1'b0; ovl_clr = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset_and_hold();
    do_reset();
    chk(bit_out == 1'b0,  "R2 bit_out", int'(bit_out), 0);
    chk(bit_valid == 1'b0, "R2 bit_valid", int'(bit_valid), 0);
    chk(ovl_flag == 1'b0,  "R2 ovl_flag", int'(ovl_flag), 0);
    chk(s_ready == 1'b0,   "R1 ready in reset", int'(s_ready), 0);
    rst = 1'b0; ovl_limit = 8'd64;
    repeat (5) @(negedge clk);
    chk(s_ready == 1'b1 && bit_valid == 1'b0 && bit_out == 1'b0,
        "R1 idle after reset", int'({s_ready, bit_valid, bit_out}), 4);
    s_valid = 1'b1;
    @(negedge clk);
    chk(bit_valid == 1'b1 && bit_out == 1'b1, "R3 first bit", int'(bit_out), 1);
    @(negedge clk);
    chk(bit_out == 1'b0, "R3 second bit", int'(bit_out), 0);
    s_valid = 1'b0;
    repeat (4) @(negedge clk);
    chk(bit_valid == 1'b0 && bit_out == 1'b0, "R1 hold without sample",
        int'({bit_valid, bit_out}), 0);
    s_valid = 1'b1;
    @(negedge clk);
    chk(bit_valid == 1'b1 && bit_out == 1'b0, "R1 resume third bit", int'(bit_out), 0);
  endtask

  task automatic t_mean(input int x, input bit dith, input string req);
    int ones;
    int expv;
    do_reset();
    rst = 1'b0; ovl_limit = '0; dither_en = dith;
    s_data = DW'(x); s_valid = 1'b1;
    repeat (512) @(negedge clk);
    ones = 0;
    for (int i = 0; i < 4096; i++) begin
      @(negedge clk);
      if (bit_out) ones++;
    end
    expv = (4096 * (FS + x)) / (2 * FS);
    chk(ones >= expv - 48 && ones <= expv + 48, req, ones, expv);
  endtask

  task automatic t_zero_idle();
    do_reset();
    rst = 1'b0; ovl_limit = 8'd64; s_data = '0; s_valid = 1'b1;
    repeat (4096) @(negedge clk);
    chk(ovl_flag == 1'b0, "R5 zero input no trip", int'(ovl_flag), 0);
  endtask

  task automatic t_overload();
    bit seen;
    do_reset();
    rst = 1'b0; ovl_limit = 8'd64; s_data = 16'sd32767; s_valid = 1'b1;
    seen = 1'b0;
    for (int i = 0; i < 5000 && !seen; i++) begin
      @(negedge clk);
      if (ovl_flag) seen = 1'b1;
    end
    chk(seen, "R6 full-scale trips", int'(seen), 1);
    s_data = '0;
    @(negedge clk);
    chk(bit_out == 1'b1, "R6 cleared state bit 1", int'(bit_out), 1);
    @(negedge clk);
    chk(bit_out == 1'b0, "R6 cleared state bit 2", int'(bit_out), 0);
    repeat (100) @(negedge clk);
    chk(ovl_flag == 1'b1, "R7 flag sticky", int'(ovl_flag), 1);
    ovl_clr = 1'b1;
    @(negedge clk);
    ovl_clr = 1'b0;
    chk(ovl_flag == 1'b0, "R7 flag cleared", int'(ovl_flag), 0);
  endtask

  task automatic t_disabled();
    do_reset();
    rst = 1'b0; ovl_limit = '0; s_data = 16'sd32767; s_valid = 1'b1;
    repeat (3000) @(negedge clk);
    chk(ovl_flag == 1'b0, "R6 limit 0 disables", int'(ovl_flag), 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset_and_hold();
    t_mean(8192, 1'b0, "R4 mean +0.25");
    t_mean(-8192, 1'b0, "R4 mean -0.25");
    t_mean(4096, 1'b1, "R8 mean with dither");
    t_zero_idle();
    t_overload();
    t_disabled();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule